// File: doc/BRIEF.md
# Multi-Gain ADC Range Selector

This block sits behind a three-path front end, in which one detector channel is amplified at relative gains of 12, 6 and 1 and each path is digitised on its own converter. On every clock (one sample per 25 ns at 40 MHz) it receives all three codes at once. It then forwards the single code that keeps the most resolution without clipping, together with a two-bit tag that names the path it came from. The combined stream covers the wide dynamic range of the lowest gain and keeps the fine steps of the highest gain for small signals.

A path counts as clipped when its code reaches a threshold that can be changed while the block runs. For full scale, tie the threshold to all ones. The paths are tried from the most sensitive to the least sensitive. The least sensitive path is the fallback, and it is used even when it is clipped too; in that case a flag warns that the value is out of range. A build option adds a second output, in which the chosen code is rescaled to the gain-12 scale (x1, x2 or x12). All outputs are registered once. There is no handshake: every clock carries a sample.

Top module: `gain_range_select`

## Requirements
- R1: While reset is asserted, out_code, out_gain, out_sat and out_lin all read zero.
- R2: When the gain-12 code is below the threshold, the output carries that code and out_gain is 2'b00.
- R3: When the gain-12 code is clipped and the gain-6 code is below the threshold, the output carries the gain-6 code and out_gain is 2'b01.
- R4: When both the gain-12 and gain-6 codes are clipped, the output carries the gain-1 code and out_gain is 2'b10. out_sat stays low if the gain-1 code is below the threshold.
- R5: out_sat is high exactly when all three codes are clipped, and out_gain is then 2'b10.
- R6: A code equal to the threshold counts as clipped; a code one below it does not. A threshold of zero clips every path.
- R7: out_gain never takes the value 2'b11.
- R8: Outputs change only at a clock edge. They reflect the inputs presented at the previous edge (one cycle of latency), and they hold their value between edges.
- R9: With the linear output enabled, out_lin equals the chosen code times 1, 2 or 12 for out_gain 2'b00, 2'b01 or 2'b10 respectively.
- R10: A new threshold applies to the very sample presented alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_g12 | input | SAMPLE_W | Code from the gain-12 path |
| samp_g6 | input | SAMPLE_W | Code from the gain-6 path |
| samp_g1 | input | SAMPLE_W | Code from the gain-1 path |
| sat_thresh | input | SAMPLE_W | Clipping threshold; a code at or above it is clipped |
| out_code | output | SAMPLE_W | Code of the selected path |
| out_gain | output | 2 | Selected path: 00 gain 12, 01 gain 6, 10 gain 1 |
| out_sat | output | 1 | All paths clipped; the gain-1 code is out of range |
| out_lin | output | LIN_W | Chosen code rescaled to the gain-12 scale (zero when disabled) |

## Verification
The bench builds the block with SAMPLE_W = 5 and LIN_W = 9, keeping the default multipliers of 2 and 12 and the linear output enabled. With 5-bit codes, every combination of the three path codes can be applied at the full-scale threshold. Every threshold from 0 to 31 can also be swept against every gain-12 code, which covers each equal-to and one-below boundary of the clipping test. The narrow linear width also puts the largest product (31 x 12) right at the top of its range.

// File: rtl/grs_pkg.sv
package grs_pkg;

   localparam int NUM_PATHS = 3;

   // Path indices, ordered from most to least sensitive
   localparam int PATH_HI  = 0;
   localparam int PATH_MID = 1;
   localparam int PATH_LO  = 2;

   typedef enum logic [1:0] {
      GAIN_HI   = 2'b00,
      GAIN_MID  = 2'b01,
      GAIN_LO   = 2'b10,
      GAIN_RSVD = 2'b11
   } gain_sel_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/grs_sat_detect.sv
module grs_sat_detect #(
   parameter int W = 12,
   parameter int N = 3
) (
   input  logic [N-1:0][W-1:0] samp,
   input  logic [W-1:0]        thresh,
   output logic [N-1:0]        clipped
);
   for (genvar p = 0; p < N; p++) begin : g_path
      assign clipped[p] = (samp[p] >= thresh);
   end
endmodule

// File: rtl/grs_prio_mux.sv
module grs_prio_mux
   import grs_pkg::*;
#(
   parameter int W = 12
) (
   input  logic [NUM_PATHS-1:0][W-1:0] samp,
   input  logic [NUM_PATHS-1:0]        clipped,
   output logic [W-1:0]                code,
   output gain_sel_e                   gain,
   output logic                        all_clipped
);
   always_comb begin
      if (!clipped[PATH_HI]) begin
         code = samp[PATH_HI];
         gain = GAIN_HI;
      end else if (!clipped[PATH_MID]) begin
         code = samp[PATH_MID];
         gain = GAIN_MID;
      end else begin
         code = samp[PATH_LO];
         gain = GAIN_LO;
      end
   end

   assign all_clipped = &clipped;
endmodule

// File: rtl/grs_lin_scale.sv
module grs_lin_scale
   import grs_pkg::*;
#(
   parameter int W        = 12,
   parameter int LW       = 16,
   parameter int MULT_MID = 2,
   parameter int MULT_LO  = 12
) (
   input  logic [W-1:0]  code,
   input  gain_sel_e     gain,
   output logic [LW-1:0] lin
);
   logic [LW-1:0] wide;
   logic [LW-1:0] scaled_mid;
   logic [LW-1:0] scaled_lo;

   assign wide = LW'(code);

   if (is_pow2(MULT_MID)) begin : g_mid_shift
      assign scaled_mid = wide << $clog2(MULT_MID);
   end else begin : g_mid_mul
      assign scaled_mid = wide * LW'(MULT_MID);
   end

   if (is_pow2(MULT_LO)) begin : g_lo_shift
      assign scaled_lo = wide << $clog2(MULT_LO);
   end else begin : g_lo_mul
      assign scaled_lo = wide * LW'(MULT_LO);
   end

   always_comb begin
      unique case (gain)
         GAIN_HI:  lin = wide;
         GAIN_MID: lin = scaled_mid;
         GAIN_LO:  lin = scaled_lo;
         default:  lin = '0;
      endcase
   end
endmodule

// File: rtl/gain_range_select.sv
module gain_range_select
   import grs_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int LIN_W    = 16,
   parameter int MULT_MID = 2,
   parameter int MULT_LO  = 12,
   parameter bit LIN_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] samp_g12,
   input  logic [SAMPLE_W-1:0] samp_g6,
   input  logic [SAMPLE_W-1:0] samp_g1,
   input  logic [SAMPLE_W-1:0] sat_thresh,
   output logic [SAMPLE_W-1:0] out_code,
   output logic [1:0]          out_gain,
   output logic                out_sat,
   output logic [LIN_W-1:0]    out_lin
);
   localparam longint MAX_CODE = (longint'(1) << SAMPLE_W) - 1;
   localparam longint MAX_LIN  = MAX_CODE * longint'(MULT_LO);

   // Elaboration-time parameter checks
   if (SAMPLE_W < 2 || SAMPLE_W > 24) begin : g_bad_w
      $error("SAMPLE_W out of supported range");
   end
   if (MULT_MID < 1 || MULT_LO < MULT_MID) begin : g_bad_mult
      $error("gain multipliers must satisfy 1 <= MULT_MID <= MULT_LO");
   end
   if (LIN_EN && (MAX_LIN >= (longint'(1) << LIN_W))) begin : g_bad_lw
      $error("LIN_W too narrow for the largest rescaled code");
   end

   logic [NUM_PATHS-1:0][SAMPLE_W-1:0] samp_vec;
   logic [NUM_PATHS-1:0]               clipped;
   logic [SAMPLE_W-1:0]                sel_code;
   gain_sel_e                          sel_gain;
   logic                               sel_all_clipped;

   assign samp_vec[PATH_HI]  = samp_g12;
   assign samp_vec[PATH_MID] = samp_g6;
   assign samp_vec[PATH_LO]  = samp_g1;

   grs_sat_detect #(
      .W (SAMPLE_W),
      .N (NUM_PATHS)
   ) u_sat (
      .samp    (samp_vec),
      .thresh  (sat_thresh),
      .clipped (clipped)
   );

   grs_prio_mux #(
      .W (SAMPLE_W)
   ) u_mux (
      .samp        (samp_vec),
      .clipped     (clipped),
      .code        (sel_code),
      .gain        (sel_gain),
      .all_clipped (sel_all_clipped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_code <= '0;
         out_gain <= GAIN_HI;
         out_sat  <= 1'b0;
      end else begin
         out_code <= sel_code;
         out_gain <= sel_gain;
         out_sat  <= sel_all_clipped;
      end
   end

   if (LIN_EN) begin : g_lin
      logic [LIN_W-1:0] lin_d;

      grs_lin_scale #(
         .W        (SAMPLE_W),
         .LW       (LIN_W),
         .MULT_MID (MULT_MID),
         .MULT_LO  (MULT_LO)
      ) u_lin (
         .code (sel_code),
         .gain (sel_gain),
         .lin  (lin_d)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) out_lin <= '0;
         else        out_lin <= lin_d;
      end
   end else begin : g_no_lin
      assign out_lin = '0;
   end
endmodule

// File: rtl/grs_checker.sv
module grs_checker #(
   parameter int SAMPLE_W = 12,
   parameter int LIN_W    = 16,
   parameter int MULT_MID = 2,
   parameter int MULT_LO  = 12,
   parameter bit LIN_EN   = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [SAMPLE_W-1:0] samp_g12,
   input logic [SAMPLE_W-1:0] samp_g6,
   input logic [SAMPLE_W-1:0] samp_g1,
   input logic [SAMPLE_W-1:0] sat_thresh,
   input logic [SAMPLE_W-1:0] out_code,
   input logic [1:0]          out_gain,
   input logic                out_sat,
   input logic [LIN_W-1:0]    out_lin
);
   logic primed;
   logic [LIN_W-1:0] lin_mid_ref, lin_lo_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assign lin_mid_ref = LIN_W'(out_code) * LIN_W'(MULT_MID);
   assign lin_lo_ref  = LIN_W'(out_code) * LIN_W'(MULT_LO);

   AST_GAIN_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      out_gain != 2'b11); // R7

   AST_HI_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(samp_g12 < sat_thresh)
      |-> out_gain == 2'b00 && out_code == $past(samp_g12)); // R2

   AST_MID_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(samp_g12 >= sat_thresh && samp_g6 < sat_thresh)
      |-> out_gain == 2'b01 && out_code == $past(samp_g6)); // R3

   AST_LO_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(samp_g12 >= sat_thresh && samp_g6 >= sat_thresh)
      |-> out_gain == 2'b10 && out_code == $past(samp_g1)); // R4

   AST_SAT_ONLY_LO: assert property (@(posedge clk) disable iff (!rst_n)
      out_sat |-> out_gain == 2'b10); // R5

   AST_SAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> out_sat == $past(samp_g12 >= sat_thresh && samp_g6 >= sat_thresh
                                  && samp_g1 >= sat_thresh)); // R5

   AST_LIN_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      LIN_EN && primed |->
         (out_gain == 2'b00 && out_lin == LIN_W'(out_code)) ||
         (out_gain == 2'b01 && out_lin == lin_mid_ref) ||
         (out_gain == 2'b10 && out_lin == lin_lo_ref)); // R9
endmodule

bind gain_range_select grs_checker #(
   .SAMPLE_W (SAMPLE_W),
   .LIN_W    (LIN_W),
   .MULT_MID (MULT_MID),
   .MULT_LO  (MULT_LO),
   .LIN_EN   (LIN_EN)
) u_grs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .samp_g12   (samp_g12),
   .samp_g6    (samp_g6),
   .samp_g1    (samp_g1),
   .sat_thresh (sat_thresh),
   .out_code   (out_code),
   .out_gain   (out_gain),
   .out_sat    (out_sat),
   .out_lin    (out_lin)
);

// File: tb/test_gain_range_select.sv
module test_gain_range_select;
   localparam int  W      = 5;
   localparam int  LW     = 9;
   localparam int  MAXV   = (1 << W) - 1;
   localparam time CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  samp_g12 = '0, samp_g6 = '0, samp_g1 = '0, sat_thresh = '1;
   logic [W-1:0]  out_code;
   logic [1:0]    out_gain;
   logic          out_sat;
   logic [LW-1:0] out_lin;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // Expected outputs of the previous sample, used for the hold check
   logic [W-1:0]  prev_code = '0;
   logic [1:0]    prev_gain = '0;
   logic          prev_sat  = 1'b0;
   logic [LW-1:0] prev_lin  = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gain_range_select #(
      .SAMPLE_W (W),
      .LIN_W    (LW)
   ) i_gain_range_select (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_g12   (samp_g12),
      .samp_g6    (samp_g6),
      .samp_g1    (samp_g1),
      .sat_thresh (sat_thresh),
      .out_code   (out_code),
      .out_gain   (out_gain),
      .out_sat    (out_sat),
      .out_lin    (out_lin)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Drive one sample at a falling edge, check that outputs hold until the
   // next rising edge, then check the registered result at the next falling edge.
   task automatic apply(input int hi, input int mid, input int lo, input int t,
                        input bit check_hold);
      int e_code, e_gain, e_sat, e_lin;
      string rtag;
      if (hi < t) begin
         e_code = hi;  e_gain = 0; e_sat = 0; e_lin = hi;      rtag = "R2";
      end else if (mid < t) begin
         e_code = mid; e_gain = 1; e_sat = 0; e_lin = mid * 2; rtag = "R3";
      end else begin
         e_code = lo;  e_gain = 2; e_sat = (lo >= t) ? 1 : 0; e_lin = lo * 12;
         rtag = e_sat ? "R5" : "R4";
      end
      samp_g12   = W'(hi);
      samp_g6    = W'(mid);
      samp_g1    = W'(lo);
      sat_thresh = W'(t);
      if (check_hold) begin
         #1;
         check("R8 hold code", int'(out_code), int'(prev_code));
         check("R8 hold gain", int'(out_gain), int'(prev_gain));
         check("R8 hold lin",  int'(out_lin),  int'(prev_lin));
      end
      @(posedge clk);
      @(negedge clk);
      check({rtag, " code"}, int'(out_code), e_code);
      check({rtag, " gain"}, int'(out_gain), e_gain);
      check("R5 sat flag",   int'(out_sat),  e_sat);
      check("R9 linear",     int'(out_lin),  e_lin);
      check("R7 no reserved gain", int'(out_gain == 2'b11), 0);
      prev_code = out_code;
      prev_gain = out_gain;
      prev_sat  = out_sat;
      prev_lin  = out_lin;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      samp_g12 = 5'd7; samp_g6 = 5'd9; samp_g1 = 5'd11;
      @(negedge clk);
      // R1: reset state
      check("R1 code", int'(out_code), 0);
      check("R1 gain", int'(out_gain), 0);
      check("R1 sat",  int'(out_sat),  0);
      check("R1 lin",  int'(out_lin),  0);
      rst_n = 1'b1;

      // Full-scale threshold: every code combination (R2..R5, R9)
      for (int hi = 0; hi <= MAXV; hi++)
         for (int mid = 0; mid <= MAXV; mid++)
            for (int lo = 0; lo <= MAXV; lo++)
               apply(hi, mid, lo, MAXV, (lo % 8) == 0);

      // R6: every threshold against every gain-12 code, incl. t and t-1
      for (int t = 0; t <= MAXV; t++)
         for (int v = 0; v <= MAXV; v++)
            apply(v, (v * 7) % (MAXV + 1), (v * 13) % (MAXV + 1), t, 1'b0);

      // R6: boundary directed cases
      apply(20, 3, 3, 20, 1'b0);   // equal to threshold -> clipped
      check("R6 equal clips", int'(out_gain), 1);
      apply(19, 3, 3, 20, 1'b0);   // one below -> kept
      check("R6 below kept", int'(out_gain), 0);
      apply(0, 0, 0, 0, 1'b0);     // zero threshold clips all
      check("R6 zero threshold", int'(out_sat), 1);

      // R10: threshold change applies to the sample presented with it
      apply(10, 2, 2, 11, 1'b1);
      check("R10 before change", int'(out_gain), 0);
      apply(10, 2, 2, 10, 1'b1);
      check("R10 after change", int'(out_gain), 1);
      check("R10 after change code", int'(out_code), 2);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule